// File: doc/BRIEF.md
# DRAM Refresh Request Arbiter

This block receives periodic refresh requests from a refresh timer and decides how each one is carried out. It keeps a small backlog of outstanding requests. When conditions allow, it serves a request as a hidden refresh inside a CPU bus cycle that does not address local DRAM. Otherwise it asks for the bus with HOLD, waits for HLDA and then refreshes. If another master already owns the bus (HLDA high without a HOLD from this block), it refreshes straight away. Each such refresh counts against the same backlog.

Sleep mode, a full backlog or a disabled hidden path all move service onto the HOLD/HLDA handshake. A separate checker watches external agents that claim cycles while hidden refresh is enabled. It flags a local-bus-access claim that is not paired with READY in the same clock, because such a claim would add wait states.

Top module: `refresh_arbiter`

## Requirements
- R1: When `rst_n` is low, `pending` is 0 and `hold`, `rfsh` and `claim_err` are all low.
- R2: Each clock with `tick` high adds one to `pending`. If no refresh ends in that clock, a full count (7 with the default 3-bit width) stays at 7 and does not wrap.
- R3: Every refresh strobe keeps `rfsh` high for exactly STROBE_LEN clocks (default 4). `pending` drops by one at the edge that ends the strobe's last clock. If a tick lands on that same clock, `pending` is left unchanged.
- R4: With `hid_en`=1, `sleep`=0, `hlda`=0 and `pending` between 1 and 6, a refresh starts only while `bus_nondram` is high, and `hold` stays low.
- R5: When `pending` reaches its maximum, `hold` is raised even though hidden refresh is enabled.
- R6: While `sleep`=1, a refresh starts only through HLDA. `hold` is raised and `rfsh` stays low until `hlda` is seen, even when `bus_nondram` is high.
- R7: With `hid_en`=0, pending requests are served through `hold`/`hlda` only.
- R8: On the HOLD path, `rfsh` starts only after `hlda` is high. `hold` falls when the strobe ends. No new request or refresh starts until `hlda` has gone low.
- R9: When `hlda` is high and `hold` is low (another master owns the bus), a pending request is refreshed at once without raising `hold`, and it lowers `pending`.
- R10: `claim_err` pulses high for one clock, one clock after `ext_lba` is high with `ext_ready` low while `hid_en`=1. It stays low for a claim that has `ext_ready` in the same clock, and for any claim while `hid_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock refresh request from the timer |
| hid_en | input | 1 | Hidden refresh enable |
| sleep | input | 1 | Sleep mode active |
| hlda | input | 1 | Bus hold acknowledge |
| bus_nondram | input | 1 | Current CPU cycle does not address local DRAM (hidden slot) |
| ext_lba | input | 1 | External local-bus-access claim strobe |
| ext_ready | input | 1 | Early READY from the claiming agent |
| hold | output | 1 | Bus hold request |
| rfsh | output | 1 | Refresh strobe |
| pending | output | CNT_W | Outstanding refresh requests |
| claim_err | output | 1 | Claim timing violation pulse |

## Verification
The assertions check on every cycle that the backlog never wraps and only falls when a strobe ends. They also check that strobes never run past their length, that any refresh started in sleep had HLDA behind it, that HOLD only falls when a strobe ends, and that every violation pulse traces back to a claim strobe. Some behaviour shows only in the bench's scenarios: which path a request takes for each mix of sleep, enable, backlog and bus ownership; the exact strobe length; the drain of a full backlog through hidden slots; and the pause after a HOLD refresh until HLDA falls.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIDDEN,
    ST_HOLD_REQ,
    ST_HOLD_RFSH,
    ST_FOREIGN,
    ST_RELEASE
  } rfa_state_e;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_HIDDEN,
    PATH_HOLD,
    PATH_FOREIGN
  } rfa_path_e;

  // next backlog value: saturating add, plain subtract
  function automatic int unsigned backlog_next(int unsigned cur, logic inc,
                                               logic dec, int unsigned maxv);
    int unsigned n;
    n = cur;
    if (inc && !dec) n = (cur == maxv) ? cur : cur + 1;
    else if (dec && !inc) n = (cur == 0) ? 0 : cur - 1;
    return n;
  endfunction

  // choice of service path for the oldest pending request
  function automatic rfa_path_e pick_path(logic pend_nz, logic full, logic hlda,
                                          logic hid_en, logic sleep, logic slot);
    rfa_path_e p;
    if (!pend_nz) p = PATH_NONE;
    else if (hlda) p = PATH_FOREIGN;
    else if (hid_en && !sleep && !full) p = slot ? PATH_HIDDEN : PATH_NONE;
    else p = PATH_HOLD;
    return p;
  endfunction

endpackage

// File: rtl/rfa_backlog.sv
module rfa_backlog #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             nz
);
  import rfa_pkg::*;

  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_nxt;

  always_comb cnt_nxt = CNT_W'(backlog_next(int'(cnt), inc, dec, MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign full = (cnt == CNT_W'(MAXV));
  assign nz   = (cnt != '0);

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(full) && !$past(dec)) |-> full);

  assert_dec_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> nz);

endmodule

// File: rtl/rfa_strobe.sv
module rfa_strobe #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      left   <= CW'(LEN - 1);
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else            left   <= left - 1'b1;
    end
  end

  assign last = active && (left == '0);

  assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left < CW'(LEN)));

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);

endmodule

// File: rtl/rfa_claim_check.sv
module rfa_claim_check (
  input  logic clk,
  input  logic rst_n,
  input  logic hid_en,
  input  logic lba,
  input  logic ready,
  output logic err
);
  logic bad_claim;

  assign bad_claim = hid_en && lba && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= bad_claim;
  end

  assert_err_has_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(lba) && !$past(ready)));

endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter #(
  parameter int CNT_W      = 3,
  parameter int STROBE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hid_en,
  input  logic             sleep,
  input  logic             hlda,
  input  logic             bus_nondram,
  input  logic             ext_lba,
  input  logic             ext_ready,
  output logic             hold,
  output logic             rfsh,
  output logic [CNT_W-1:0] pending,
  output logic             claim_err
);
  import rfa_pkg::*;

  rfa_state_e state;
  rfa_path_e  path;
  logic       pend_full, pend_nz;
  logic       strobe_start, strobe_last;
  logic       hold_q;

  rfa_backlog #(.CNT_W(CNT_W)) u_backlog (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(strobe_last),
    .cnt(pending), .full(pend_full), .nz(pend_nz)
  );

  rfa_strobe #(.LEN(STROBE_LEN)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(strobe_start),
    .active(rfsh), .last(strobe_last)
  );

  rfa_claim_check u_claim (
    .clk(clk), .rst_n(rst_n), .hid_en(hid_en), .lba(ext_lba),
    .ready(ext_ready), .err(claim_err)
  );

  always_comb path = pick_path(pend_nz, pend_full, hlda, hid_en, sleep, bus_nondram);

  always_comb begin
    strobe_start = 1'b0;
    if (state == ST_IDLE && (path == PATH_HIDDEN || path == PATH_FOREIGN))
      strobe_start = 1'b1;
    if (state == ST_HOLD_REQ && hlda)
      strobe_start = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hold_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (path == PATH_HIDDEN)  state <= ST_HIDDEN;
          if (path == PATH_FOREIGN) state <= ST_FOREIGN;
          if (path == PATH_HOLD) begin
            state  <= ST_HOLD_REQ;
            hold_q <= 1'b1;
          end
        end
        ST_HOLD_REQ:  if (hlda) state <= ST_HOLD_RFSH;
        ST_HOLD_RFSH: if (strobe_last) begin
          hold_q <= 1'b0;
          state  <= ST_RELEASE;
        end
        ST_HIDDEN, ST_FOREIGN: if (strobe_last) state <= ST_IDLE;
        ST_RELEASE: if (!hlda) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hold = hold_q;

  assert_sleep_uses_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rfsh) && $past(sleep)) |-> $past(hlda));

  assert_hold_drop_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(strobe_last));

  assert_hold_waits_hlda_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rfsh) && $past(hold)) |-> $past(hlda));

  assert_dec_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending < $past(pending)) |-> $past(strobe_last));

endmodule

// File: tb/test_refresh_arbiter.sv
module test_refresh_arbiter;
  localparam int CNT_W = 3;
  localparam int SLEN  = 4;
  localparam int PMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hid_en = 1'b0, sleep = 1'b0, hlda = 1'b0;
  logic bus_nondram = 1'b0, ext_lba = 1'b0, ext_ready = 1'b0;
  logic hold, rfsh, claim_err;
  logic [CNT_W-1:0] pending;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  refresh_arbiter #(.CNT_W(CNT_W), .STROBE_LEN(SLEN)) i_refresh_arbiter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hid_en(hid_en), .sleep(sleep),
    .hlda(hlda), .bus_nondram(bus_nondram), .ext_lba(ext_lba),
    .ext_ready(ext_ready), .hold(hold), .rfsh(rfsh), .pending(pending),
    .claim_err(claim_err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(1); tick = 1'b0;
  endtask

  // waits for a strobe, returns its length; -1 on timeout
  task automatic run_strobe(output int len);
    int t;
    t = 0;
    while (!rfsh && t < 300) begin step(1); t++; end
    if (!rfsh) len = -1;
    else begin
      len = 0;
      while (rfsh) begin len++; step(1); end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(3);
    chk(pending == 0 && !hold && !rfsh && !claim_err, "R1", int'(pending), 0);
    rst_n = 1'b1; step(1);
  endtask

  task automatic t_hidden();
    int len;
    hid_en = 1'b1; sleep = 1'b0; hlda = 1'b0; bus_nondram = 1'b0;
    pulse_tick(); step(4);
    chk(pending == 1, "R2", int'(pending), 1);
    chk(!rfsh && !hold, "R4 waits for slot", int'(rfsh), 0);
    bus_nondram = 1'b1;
    run_strobe(len);
    chk(len == SLEN, "R3 strobe length", len, SLEN);
    chk(pending == 0, "R3 decrement", int'(pending), 0);
    chk(!hold, "R4 no hold", int'(hold), 0);
    bus_nondram = 1'b0; step(2);
  endtask

  task automatic t_saturate();
    int len, t, hold_seen;
    hid_en = 1'b1; bus_nondram = 1'b0;
    for (int i = 0; i < PMAX + 2; i++) pulse_tick();
    step(2);
    chk(pending == PMAX, "R2 saturation", int'(pending), PMAX);
    chk(hold == 1'b1, "R5 forced hold", int'(hold), 1);
    chk(!rfsh, "R8 no strobe before hlda", int'(rfsh), 0);
    hlda = 1'b1;
    run_strobe(len);
    chk(len == SLEN, "R8 strobe after hlda", len, SLEN);
    chk(!hold, "R8 hold released", int'(hold), 0);
    chk(pending == PMAX - 1, "R3 one credit", int'(pending), PMAX - 1);
    hlda = 1'b0; step(2);
    bus_nondram = 1'b1;
    hold_seen = 0; t = 0;
    while (pending != 0 && t < 500) begin
      if (hold) hold_seen = 1;
      step(1); t++;
    end
    chk(pending == 0 && hold_seen == 0, "R4 drain by hidden", int'(pending), 0);
    bus_nondram = 1'b0; step(SLEN + 2);
  endtask

  task automatic t_sleep();
    int len, bad;
    hid_en = 1'b1; sleep = 1'b1; bus_nondram = 1'b1; hlda = 1'b0;
    pulse_tick();
    bad = 0;
    for (int i = 0; i < 5; i++) begin if (rfsh) bad = 1; step(1); end
    chk(hold && bad == 0, "R6 sleep uses hold", int'(bad), 0);
    hlda = 1'b1;
    run_strobe(len);
    chk(len == SLEN && pending == 0, "R6 serviced via hlda", len, SLEN);
    // hlda still high: a new request must wait
    pulse_tick();
    bad = 0;
    for (int i = 0; i < 4; i++) begin if (rfsh || hold) bad = 1; step(1); end
    chk(bad == 0 && pending == 1, "R8 waits for hlda low", int'(pending), 1);
    hlda = 1'b0; step(3);
    chk(hold == 1'b1, "R8 new hold after release", int'(hold), 1);
    hlda = 1'b1;
    run_strobe(len);
    hlda = 1'b0; sleep = 1'b0; bus_nondram = 1'b0; step(3);
    chk(pending == 0 && !hold, "R6 second service", int'(pending), 0);
  endtask

  task automatic t_disabled();
    int len, bad;
    hid_en = 1'b0; bus_nondram = 1'b1; hlda = 1'b0;
    pulse_tick();
    bad = 0;
    for (int i = 0; i < 4; i++) begin if (rfsh) bad = 1; step(1); end
    chk(hold && bad == 0, "R7 disabled uses hold", int'(hold), 1);
    hlda = 1'b1;
    run_strobe(len);
    chk(len == SLEN && pending == 0, "R7 serviced", int'(pending), 0);
    hlda = 1'b0; bus_nondram = 1'b0; step(3);
  endtask

  task automatic t_foreign();
    int len, hold_seen, p_before;
    hid_en = 1'b1; bus_nondram = 1'b0; hlda = 1'b1; step(1);
    pulse_tick();
    hold_seen = 0;
    while (!rfsh) begin if (hold) hold_seen = 1; step(1); end
    // tick landing on the last strobe clock leaves the count alone
    step(SLEN - 1);
    p_before = int'(pending);
    tick = 1'b1; step(1); tick = 1'b0;
    chk(int'(pending) == p_before, "R3 tick on last clock", int'(pending), p_before);
    chk(hold_seen == 0 && !hold, "R9 no hold", int'(hold), 0);
    run_strobe(len);
    chk(len == SLEN && pending == 0, "R9 credit", int'(pending), 0);
    hlda = 1'b0; step(2);
  endtask

  task automatic t_claim();
    hid_en = 1'b1;
    ext_lba = 1'b1; ext_ready = 1'b1; step(1);
    ext_lba = 1'b0; ext_ready = 1'b0;
    chk(!claim_err, "R10 ready claim ok", int'(claim_err), 0);
    ext_lba = 1'b1; step(1); ext_lba = 1'b0;
    chk(claim_err, "R10 late claim flagged", int'(claim_err), 1);
    step(1);
    chk(!claim_err, "R10 single pulse", int'(claim_err), 0);
    hid_en = 1'b0;
    ext_lba = 1'b1; step(1); ext_lba = 1'b0;
    chk(!claim_err, "R10 disabled no flag", int'(claim_err), 0);
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_hidden();
    t_saturate();
    t_sleep();
    t_disabled();
    t_foreign();
    t_claim();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule